// File: doc/BRIEF.md
# Banked Stack Pointer Access Control

This block keeps two 64-bit stack pointers, one for the least privileged level and one for the first privileged level, and decides which of them is the current stack pointer. It also handles explicit system-register requests aimed at the level-1 pointer. For each request it returns exactly one outcome: the access completes, it is undefined, it traps to level 2 with a syndrome class, or it is redirected to a memory slot at a fixed byte offset.

A decoded request arrives with a strobe, a read/write flag, the five encoding fields and 64 bits of write data. The current privilege level (0 to 3) and three virtualization control bits decide the outcome in the same cycle. A write changes the level-1 pointer on the next clock edge, and only when the outcome is complete. A redirected access leaves both pointers alone and hands a load/store indication and the byte offset to a memory unit outside the block.

Top module: `spbk_ctl`

## Requirements
- R1: An outcome is raised only when the strobe is high and the encoding is op0=2'b11, op1=3'b100, CRn=4'b0100, CRm=4'b0001, op2=3'b000. In every other case no outcome is raised and no pointer changes.
- R2: A claimed request at privilege level 0 gives the undefined outcome, for both read and write.
- R3: At level 1 with virtualization bits 2 and 0 both set (bit 1 ignored), the outcome is redirect with byte offset 0x240. The redirect write flag equals the request's write flag, and the pointer is neither read nor written.
- R4: At level 1 with virtualization bit 0 set and bit 2 clear, the outcome is a trap to level 2 with syndrome class 0x18.
- R5: At level 1 with virtualization bit 0 clear, the outcome is undefined.
- R6: At level 2 or 3, a claimed read completes and returns all 64 bits of the level-1 pointer on the read data output.
- R7: At level 2 or 3, a claimed write completes and replaces all 64 bits of the level-1 pointer at the next clock edge.
- R8: The current stack pointer output is the level-1 pointer when the level is 1 and the select bit is 1. Otherwise it is the level-0 pointer.
- R9: The complete, undefined, trap and redirect outcomes are never raised together. Read data is zero unless a read completes. Trap class and offset are zero unless their own outcome is raised.
- R10: After reset both pointers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request strobe |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_wdata | input | 64 | Write data |
| priv_lvl | input | 2 | Current privilege level |
| stk_sel | input | 1 | Stack select bit |
| virt_ctl | input | 3 | Virtualization control bits |
| rd_data | output | 64 | Read data |
| cur_sp | output | 64 | Current stack pointer |
| res_done | output | 1 | Access completed |
| res_undef | output | 1 | Undefined outcome |
| res_trap | output | 1 | Trap to level 2 |
| trap_class | output | 6 | Syndrome class when trapping |
| res_redir | output | 1 | Redirect to memory |
| redir_wr | output | 1 | Redirect is a store |
| redir_ofs | output | 12 | Redirect byte offset |

## Verification
Two things can happen in the same cycle. An access can resolve to trap, redirect, undefined or a completed write, and in that same cycle the current pointer output is selected by the same level input. The bench sets the select bit to 1 at level 1 while issuing redirected and trapped writes. It then checks that the current pointer still shows the old level-1 value in that cycle and the next. It also follows a completed write at level 2 with a level-1 cycle and checks that the new value appears on the current pointer only after the clock edge.

// File: rtl/spbk_pkg.sv
package spbk_pkg;
  typedef enum logic [2:0] {
    OUT_NONE  = 3'd0,
    OUT_DONE  = 3'd1,
    OUT_UNDEF = 3'd2,
    OUT_TRAP  = 3'd3,
    OUT_REDIR = 3'd4
  } outcome_e;

  localparam logic [1:0] ENC_OP0 = 2'b11;
  localparam logic [2:0] ENC_OP1 = 3'b100;
  localparam logic [3:0] ENC_CRN = 4'b0100;
  localparam logic [3:0] ENC_CRM = 4'b0001;
  localparam logic [2:0] ENC_OP2 = 3'b000;
endpackage

// File: rtl/spbk_rst_sync.sv
module spbk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shreg_q;
  logic [STAGES-1:0] shreg_d;

  always_comb shreg_d = {shreg_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= '0;
    else        shreg_q <= shreg_d;
  end

  assign rst_sync_n = shreg_q[STAGES-1];
endmodule

// File: rtl/spbk_decode.sv
module spbk_decode
  import spbk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_vld,
  input  logic [1:0] req_op0,
  input  logic [2:0] req_op1,
  input  logic [3:0] req_crn,
  input  logic [3:0] req_crm,
  input  logic [2:0] req_op2,
  input  logic [1:0] priv_lvl,
  input  logic [2:0] virt_ctl,
  output outcome_e   outcome
);
  logic enc_hit;

  always_comb begin
    enc_hit = (req_op0 == ENC_OP0) && (req_op1 == ENC_OP1) &&
              (req_crn == ENC_CRN) && (req_crm == ENC_CRM) &&
              (req_op2 == ENC_OP2);
    outcome = OUT_NONE;
    if (req_vld && enc_hit) begin
      unique case (priv_lvl)
        2'd0: outcome = OUT_UNDEF;
        2'd1: begin
          if (virt_ctl[2] && virt_ctl[0]) outcome = OUT_REDIR;
          else if (virt_ctl[0])           outcome = OUT_TRAP;
          else                            outcome = OUT_UNDEF;
        end
        default: outcome = OUT_DONE;
      endcase
    end
  end

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |-> (outcome == OUT_NONE));
  assert_lvl0_undef_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && priv_lvl == 2'd0 && outcome != OUT_NONE) |-> (outcome == OUT_UNDEF));
  assert_high_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_lvl[1] && outcome != OUT_NONE) |-> (outcome == OUT_DONE));
endmodule

// File: rtl/spbk_bank.sv
module spbk_bank #(
  parameter int DW   = 64,
  parameter int NREG = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREG-1:0]          wr_en,
  input  logic [DW-1:0]            wdata,
  output logic [NREG-1:0][DW-1:0]  regs_q
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] reg_d;

    always_comb begin
      reg_d = regs_q[g];
      if (wr_en[g]) reg_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= '0;
      else        regs_q[g] <= reg_d;
    end

    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en[g] |=> $stable(regs_q[g]));
    assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[g] |=> (regs_q[g] == $past(wdata)));
  end
endmodule

// File: rtl/spbk_ctl.sv
module spbk_ctl
  import spbk_pkg::*;
#(
  parameter int          DW         = 64,
  parameter int          CLS_W      = 6,
  parameter int          OFS_W      = 12,
  parameter logic [5:0]  TRAP_CLS   = 6'h18,
  parameter logic [11:0] REDIR_BYTE = 12'h240
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld,
  input  logic             req_wr,
  input  logic [1:0]       req_op0,
  input  logic [2:0]       req_op1,
  input  logic [3:0]       req_crn,
  input  logic [3:0]       req_crm,
  input  logic [2:0]       req_op2,
  input  logic [DW-1:0]    req_wdata,
  input  logic [1:0]       priv_lvl,
  input  logic             stk_sel,
  input  logic [2:0]       virt_ctl,
  output logic [DW-1:0]    rd_data,
  output logic [DW-1:0]    cur_sp,
  output logic             res_done,
  output logic             res_undef,
  output logic             res_trap,
  output logic [CLS_W-1:0] trap_class,
  output logic             res_redir,
  output logic             redir_wr,
  output logic [OFS_W-1:0] redir_ofs
);
  localparam int NREG = 2;
  localparam int IDX0 = 0;
  localparam int IDX1 = 1;

  logic                    rst_core_n;
  outcome_e                outcome;
  logic [NREG-1:0]         wr_en;
  logic [NREG-1:0][DW-1:0] sp_q;

  spbk_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  spbk_decode i_decode (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .req_vld  (req_vld),
    .req_op0  (req_op0),
    .req_op1  (req_op1),
    .req_crn  (req_crn),
    .req_crm  (req_crm),
    .req_op2  (req_op2),
    .priv_lvl (priv_lvl),
    .virt_ctl (virt_ctl),
    .outcome  (outcome)
  );

  always_comb begin
    res_done   = (outcome == OUT_DONE);
    res_undef  = (outcome == OUT_UNDEF);
    res_trap   = (outcome == OUT_TRAP);
    res_redir  = (outcome == OUT_REDIR);
    trap_class = res_trap  ? TRAP_CLS[CLS_W-1:0]   : '0;
    redir_ofs  = res_redir ? REDIR_BYTE[OFS_W-1:0] : '0;
    redir_wr   = res_redir && req_wr;
    wr_en       = '0;
    wr_en[IDX1] = res_done && req_wr;
    rd_data     = (res_done && !req_wr) ? sp_q[IDX1] : '0;
    cur_sp      = (priv_lvl == 2'd1 && stk_sel) ? sp_q[IDX1] : sp_q[IDX0];
  end

  spbk_bank #(.DW(DW), .NREG(NREG)) i_bank (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .wr_en  (wr_en),
    .wdata  (req_wdata),
    .regs_q (sp_q)
  );

  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0({res_done, res_undef, res_trap, res_redir}));
  assert_rd_zero_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    !res_done |-> (rd_data == '0));
  assert_redir_keep_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    res_redir |=> $stable(sp_q[IDX1]));
  assert_trap_cls_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    res_trap |-> (trap_class == TRAP_CLS[CLS_W-1:0]));
endmodule

// File: tb/test_spbk_ctl.sv
module test_spbk_ctl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld, req_wr, stk_sel;
  logic [1:0]  req_op0, priv_lvl;
  logic [2:0]  req_op1, req_op2, virt_ctl;
  logic [3:0]  req_crn, req_crm;
  logic [63:0] req_wdata, rd_data, cur_sp;
  logic        res_done, res_undef, res_trap, res_redir, redir_wr;
  logic [5:0]  trap_class;
  logic [11:0] redir_ofs;

  int checks = 0;
  int errors = 0;
  logic [63:0] m_sp1 = 64'd0;
  bit finished = 0;

  always #4 clk = ~clk;

  spbk_ctl i_spbk_ctl (.*);

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_out(input logic vld, input logic [1:0] o0, input logic [2:0] o1,
                                 input logic [3:0] cn, input logic [3:0] cm, input logic [2:0] o2,
                                 input logic [1:0] lvl, input logic [2:0] vc);
    if (!(vld && o0 == 2'b11 && o1 == 3'b100 && cn == 4'b0100 && cm == 4'b0001 && o2 == 3'b000)) return 0;
    if (lvl == 2'd0) return 2;
    if (lvl == 2'd1) begin
      if (vc[2] && vc[0]) return 4;
      if (vc[0]) return 3;
      return 2;
    end
    return 1;
  endfunction

  function automatic string tag_of(input int e, input logic [1:0] lvl, input logic wr);
    case (e)
      0: return "R1";
      2: return (lvl == 2'd0) ? "R2" : "R5";
      3: return "R4";
      4: return "R3";
      default: return wr ? "R7" : "R6";
    endcase
  endfunction

  task automatic step(input logic vld, input logic wr, input logic [1:0] o0, input logic [2:0] o1,
                      input logic [3:0] cn, input logic [3:0] cm, input logic [2:0] o2,
                      input logic [63:0] wd, input logic [1:0] lvl, input logic sel, input logic [2:0] vc);
    int e;
    string t;
    @(negedge clk);
    req_vld = vld; req_wr = wr; req_op0 = o0; req_op1 = o1; req_crn = cn; req_crm = cm;
    req_op2 = o2; req_wdata = wd; priv_lvl = lvl; stk_sel = sel; virt_ctl = vc;
    #2;
    e = exp_out(vld, o0, o1, cn, cm, o2, lvl, vc);
    t = tag_of(e, lvl, wr);
    chk(t, "outcome", {60'd0, res_redir, res_trap, res_undef, res_done},
        {60'd0, e == 4, e == 3, e == 2, e == 1});
    chk("R4", "trap_class", {58'd0, trap_class}, (e == 3) ? 64'h18 : 64'h0);
    chk("R3", "redir", {51'd0, redir_wr, redir_ofs}, (e == 4) ? {51'd0, wr, 12'h240} : 64'h0);
    chk((e == 1) ? "R6" : "R9", "rd_data", rd_data, (e == 1 && !wr) ? m_sp1 : 64'h0);
    chk("R8", "cur_sp", cur_sp, (lvl == 2'd1 && sel) ? m_sp1 : 64'h0);
    @(posedge clk);
    if (e == 1 && wr) m_sp1 = wd;
  endtask

  task automatic acc(input logic wr, input logic [63:0] wd, input logic [1:0] lvl, input logic sel, input logic [2:0] vc);
    step(1'b1, wr, 2'b11, 3'b100, 4'b0100, 4'b0001, 3'b000, wd, lvl, sel, vc);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_vld = 0; req_wr = 0; req_op0 = 0; req_op1 = 0; req_crn = 0; req_crm = 0; req_op2 = 0;
    req_wdata = 0; priv_lvl = 0; stk_sel = 0; virt_ctl = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R10: both pointers zero after reset
    @(negedge clk); priv_lvl = 2'd1; stk_sel = 1'b1; #2;
    chk("R10", "level-1 pointer after reset", cur_sp, 64'h0);
    stk_sel = 1'b0; #1;
    chk("R10", "level-0 pointer after reset", cur_sp, 64'h0);
    acc(1'b0, 64'h0, 2'd2, 1'b0, 3'b000);
    // R2 level 0
    acc(1'b1, 64'hDEAD, 2'd0, 1'b1, 3'b101);
    acc(1'b0, 64'h0, 2'd0, 1'b0, 3'b000);
    // R7 full write at level 2, then visible at level 1
    acc(1'b1, 64'hFEDC_BA98_7654_3210, 2'd2, 1'b1, 3'b000);
    acc(1'b0, 64'h0, 2'd1, 1'b1, 3'b000);
    acc(1'b0, 64'h0, 2'd3, 1'b0, 3'b111);
    // every virtualization pattern at level 1 with a write while select is 1 (R3, R4, R5)
    for (int v = 0; v < 8; v++) acc(1'b1, 64'h1111_0000 + 64'(v), 2'd1, 1'b1, 3'(v));
    acc(1'b0, 64'h0, 2'd3, 1'b0, 3'b000);
    acc(1'b0, 64'h0, 2'd1, 1'b0, 3'b111);
    // R1: each field off by one, strobe low
    step(1, 1, 2'b10, 3'b100, 4'b0100, 4'b0001, 3'b000, 64'h5, 2'd2, 0, 0);
    step(1, 1, 2'b11, 3'b101, 4'b0100, 4'b0001, 3'b000, 64'h5, 2'd2, 0, 0);
    step(1, 1, 2'b11, 3'b100, 4'b0101, 4'b0001, 3'b000, 64'h5, 2'd2, 0, 0);
    step(1, 1, 2'b11, 3'b100, 4'b0100, 4'b0000, 3'b000, 64'h5, 2'd2, 0, 0);
    step(1, 1, 2'b11, 3'b100, 4'b0100, 4'b0001, 3'b001, 64'h5, 2'd2, 0, 0);
    step(0, 1, 2'b11, 3'b100, 4'b0100, 4'b0001, 3'b000, 64'h5, 2'd3, 0, 0);
    acc(1'b0, 64'h0, 2'd2, 1'b1, 3'b000);
    // all-ones write then read (R7, R6)
    acc(1'b1, '1, 2'd3, 1'b0, 3'b000);
    acc(1'b0, 64'h0, 2'd2, 1'b0, 3'b000);
    // random mix, fixed seed
    void'($urandom(32'd20240607));
    for (int i = 0; i < 600; i++) begin
      logic hit;
      hit = ($urandom % 4) != 0;
      if (hit)
        step(($urandom % 8) != 0, 1'($urandom), 2'b11, 3'b100, 4'b0100, 4'b0001, 3'b000,
             {$urandom, $urandom}, 2'($urandom), 1'($urandom), 3'($urandom));
      else
        step(1'($urandom), 1'($urandom), 2'($urandom), 3'($urandom), 4'($urandom), 4'($urandom),
             3'($urandom), {$urandom, $urandom}, 2'($urandom), 1'($urandom), 3'($urandom));
    end
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule